// File: doc/BRIEF.md
# Edge-Timeout Serial Bit Decoder

This block turns a drive read line into bytes. A falling edge on the line counts as a 1 bit. A bit cell that ends with no edge counts as a 0 bit. The zero cells are not taken from a fixed sampling grid. A timer starts again at every event, whether that event was an edge or an expired timer, and a 0 is produced each time the timer runs out. A quiet line would give an endless run of zeros, so the block keeps an idle state. While idle, timer expiries store nothing. The first edge ends the idle state, and a fixed number of zeros in a row brings it back.

The recovered bits enter a shift register with the first bit at the most significant end. When a byte is complete it goes to a parallel output, a ready flag is raised for the host, and the shift register starts again from empty. The host answers with an acknowledge. If the next byte completes before that acknowledge arrives, a sticky overrun flag is set.

Top module: `edge_timeout_decoder`

## Requirements
- R1: A falling edge on `rdIn` (high to low), taken through a two-flop synchronizer, stores a 1 bit.
- R2: When the block is not idle and `TIMEOUT_CYCLES` clock cycles pass with no event, a 0 bit is stored. The timer restarts after every event of either kind, so consecutive zeros are exactly one timeout apart.
- R3: After reset, and again after `MAX_ZEROS` consecutive stored zeros (default 3), the block is idle. While idle, timer expiries store nothing, and the next edge leaves the idle state and stores a 1.
- R4: If an edge and a timer expiry fall in the same cycle, only the 1 from the edge is stored, and the timer restarts.
- R5: Bits are packed with the first received bit in `byteOut[7]`. Each group of 8 stored bits forms one byte, after which the shift register and bit count restart from zero.
- R6: `byteReady` rises in the cycle a byte is loaded onto `byteOut`. It stays high, with `byteOut` held, until `ack` is sampled high. It is low in the following cycle unless another byte completes in that same cycle.
- R7: If a byte completes while `byteReady` is high and `ack` is low, `overrun` goes high and stays high until reset, and `byteOut` shows the newer byte.
- R8: A synchronous reset (`rst` high) leaves `byteReady` low, `overrun` low, `byteOut` zero, the bit count at zero, and the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdIn | input | 1 | Asynchronous read line; a falling edge marks a 1 |
| ack | input | 1 | Host acknowledge of the presented byte |
| byteOut | output | 8 | Most recently completed byte, first bit in bit 7 |
| byteReady | output | 1 | High while a byte waits for acknowledge |
| overrun | output | 1 | Sticky flag: a byte completed before the previous one was acknowledged |

## Verification
The hardest case to reach from the ports is an edge that lands in exactly the same cycle as a timer expiry (R4). Almost any stimulus lets one of the two win by a cycle. The bench places its falling edges on the input a whole number of timeout periods apart, counted in clock cycles. Because the synchronizer and edge detector add the same delay to every edge, the detected edge then meets the expiry exactly, and the two priority outcomes give different byte values. A zero run longer than `MAX_ZEROS` and a byte that completes before the host acknowledges are each driven on purpose to exercise the idle return and the overrun flag.

// File: rtl/ebd_pkg.sv
package ebd_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic push;    // store one bit into the shift register
    logic bitVal;  // value of the stored bit
    logic commit;  // this bit completes a byte
  } ebdStrobes_t;
endpackage

// File: rtl/ebd_datapath.sv
module ebd_datapath
  import ebd_pkg::*;
#(
  parameter int BYTE_BITS      = 8,
  parameter int TIMEOUT_CYCLES = 187,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rdIn,
  input  ebdStrobes_t          strobes,
  output logic                 edgeEv,
  output logic                 timeoutEv,
  output logic [BYTE_BITS-1:0] byteOut
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncPrev;
  logic [TW-1:0]          timerQ;
  logic [BYTE_BITS-1:0]   shiftQ;
  logic [BYTE_BITS-1:0]   byteQ;
  logic [BYTE_BITS-1:0]   shiftNext;

  // Synchronizer chain and edge history, reset to line-high
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= '1;
      syncPrev <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], rdIn};
      syncPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign edgeEv    = syncPrev & ~syncQ[SYNC_STAGES-1];
  assign timeoutEv = (timerQ == TLAST);

  // Bit-cell timer: restarts on any event
  always_ff @(posedge clk) begin
    if (rst || edgeEv || timeoutEv) timerQ <= '0;
    else                            timerQ <= timerQ + 1'b1;
  end

  assign shiftNext = {shiftQ[BYTE_BITS-2:0], strobes.bitVal};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      byteQ  <= '0;
    end else if (strobes.commit) begin
      byteQ  <= shiftNext;
      shiftQ <= '0;
    end else if (strobes.push) begin
      shiftQ <= shiftNext;
    end
  end

  assign byteOut = byteQ;
endmodule

// File: rtl/ebd_control.sv
module ebd_control
  import ebd_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int MAX_ZEROS = 3,
  localparam int CW = $clog2(BYTE_BITS),
  localparam int ZW = $clog2(MAX_ZEROS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edgeEv,
  input  logic          timeoutEv,
  input  logic          ack,
  output ebdStrobes_t   strobes,
  output logic          byteReady,
  output logic          overrun,
  output logic          idleState,
  output logic [CW-1:0] bitCount
);
  localparam logic [CW-1:0] CLAST = CW'(BYTE_BITS - 1);
  localparam logic [ZW-1:0] ZLAST = ZW'(MAX_ZEROS - 1);

  logic          idleQ;
  logic [ZW-1:0] zeroRunQ;
  logic [CW-1:0] countQ;
  logic          readyQ;
  logic          overrunQ;
  logic          zeroStore;
  logic          store;

  assign zeroStore = timeoutEv & ~edgeEv & ~idleQ;
  assign store     = edgeEv | zeroStore;

  always_comb begin
    strobes.push   = store;
    strobes.bitVal = edgeEv;
    strobes.commit = store && (countQ == CLAST);
  end

  // Idle tracking and zero-run length
  always_ff @(posedge clk) begin
    if (rst) begin
      idleQ    <= 1'b1;
      zeroRunQ <= '0;
    end else if (edgeEv) begin
      idleQ    <= 1'b0;
      zeroRunQ <= '0;
    end else if (zeroStore) begin
      if (zeroRunQ == ZLAST) begin
        idleQ    <= 1'b1;
        zeroRunQ <= '0;
      end else begin
        zeroRunQ <= zeroRunQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 countQ <= '0;
    else if (strobes.commit) countQ <= '0;
    else if (store)          countQ <= countQ + 1'b1;
  end

  // Host handshake and overrun
  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ   <= 1'b0;
      overrunQ <= 1'b0;
    end else begin
      if (strobes.commit) readyQ <= 1'b1;
      else if (ack)       readyQ <= 1'b0;
      if (strobes.commit && readyQ && !ack) overrunQ <= 1'b1;
    end
  end

  assign byteReady = readyQ;
  assign overrun   = overrunQ;
  assign idleState = idleQ;
  assign bitCount  = countQ;
endmodule

// File: rtl/edge_timeout_decoder.sv
module edge_timeout_decoder
  import ebd_pkg::*;
#(
  parameter int BYTE_BITS      = 8,
  parameter int TIMEOUT_CYCLES = 187,
  parameter int MAX_ZEROS      = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rdIn,
  input  logic                 ack,
  output logic [BYTE_BITS-1:0] byteOut,
  output logic                 byteReady,
  output logic                 overrun
);
  localparam int CW = $clog2(BYTE_BITS);

  ebdStrobes_t   strobes;
  logic          edgeEv;
  logic          timeoutEv;
  logic          idleState;
  logic [CW-1:0] bitCount;

  ebd_datapath #(
    .BYTE_BITS(BYTE_BITS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .rdIn(rdIn), .strobes(strobes),
    .edgeEv(edgeEv), .timeoutEv(timeoutEv), .byteOut(byteOut)
  );

  ebd_control #(
    .BYTE_BITS(BYTE_BITS),
    .MAX_ZEROS(MAX_ZEROS)
  ) u_ctl (
    .clk(clk), .rst(rst), .edgeEv(edgeEv), .timeoutEv(timeoutEv),
    .ack(ack), .strobes(strobes), .byteReady(byteReady),
    .overrun(overrun), .idleState(idleState), .bitCount(bitCount)
  );
endmodule

// File: rtl/ebd_checker.sv
module ebd_checker #(
  parameter int BYTE_BITS = 8,
  localparam int CW = $clog2(BYTE_BITS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ack,
  input logic [BYTE_BITS-1:0] byteOut,
  input logic                 byteReady,
  input logic                 overrun,
  input logic                 edgeEv,
  input logic                 timeoutEv,
  input logic                 idleState,
  input logic [CW-1:0]        bitCount
);
  // R1
  edge_stores_chk: assert property (@(posedge clk) disable iff (rst)
    edgeEv |=> (bitCount == CW'($past(bitCount) + 1'b1)) || (bitCount == '0));

  // R3
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (idleState && timeoutEv && !edgeEv) |=> $stable(bitCount));

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (byteReady && !ack) |=> byteReady);

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(byteReady) |-> $past(ack));

  // R6
  byte_held_chk: assert property (@(posedge clk) disable iff (rst)
    (byteReady && !ack) |=> ($stable(byteOut) || overrun));

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> ($past(byteReady) && !$past(ack)));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind edge_timeout_decoder ebd_checker #(.BYTE_BITS(BYTE_BITS)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .byteOut(byteOut),
  .byteReady(byteReady), .overrun(overrun), .edgeEv(edgeEv),
  .timeoutEv(timeoutEv), .idleState(idleState), .bitCount(bitCount)
);

// File: tb/test_edge_timeout_decoder.sv
module test_edge_timeout_decoder;
  localparam int T  = 187;
  localparam int MZ = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rdIn = 1'b1;
  logic       ack;
  logic [7:0] byteOut;
  logic       byteReady;
  logic       overrun;

  logic autoAck = 1'b1;
  logic ackAuto = 1'b0;
  logic manualAck = 1'b0;
  assign ack = autoAck ? ackAuto : manualAck;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int expShift, expCnt, nExp, nRx;
  int expBytes [0:31];
  int rxBytes  [0:31];

  always #4 clk = ~clk;  // 125 MHz

  edge_timeout_decoder #(.TIMEOUT_CYCLES(T), .MAX_ZEROS(MZ)) i_edge_timeout_decoder (
    .clk(clk), .rst(rst), .rdIn(rdIn), .ack(ack),
    .byteOut(byteOut), .byteReady(byteReady), .overrun(overrun)
  );

  // Host: captures and acknowledges each byte when autoAck is on
  initial begin
    forever begin
      @(negedge clk);
      if (autoAck && byteReady && !ackAuto) begin
        if (nRx < 32) rxBytes[nRx] = byteOut;
        nRx++;
        ackAuto = 1'b1;
      end else begin
        ackAuto = 1'b0;
      end
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelPush(input int b);
    expShift = ((expShift << 1) | b) & 8'hFF;
    expCnt++;
    if (expCnt == 8) begin
      if (nExp < 32) expBytes[nExp] = expShift;
      nExp++;
      expCnt = 0;
      expShift = 0;
    end
  endtask

  task automatic doReset();
    rst = 1'b1; rdIn = 1'b1; autoAck = 1'b1; manualAck = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expShift = 0; expCnt = 0; nExp = 0; nRx = 0;
  endtask

  // Falling edge placed 'spacing' cycles after the previous one
  task automatic emitEdge(input int spacing);
    if (spacing > 4) repeat (spacing - 4) @(negedge clk);
    rdIn = 1'b0;
    repeat (4) @(negedge clk);
    rdIn = 1'b1;
  endtask

  task automatic oneAfterZeros(input int k, input bit first);
    if (first) emitEdge(0);
    else begin
      emitEdge(k * T + T / 2);
      for (int i = 0; i < ((k < MZ) ? k : MZ); i++) modelPush(0);
    end
    modelPush(1);
  endtask

  task automatic closeStream();
    repeat ((MZ + 2) * T) @(negedge clk);
    for (int i = 0; i < MZ; i++) modelPush(0);
  endtask

  task automatic compareStream(input string tag);
    checkEq({tag, " byte count"}, nRx, nExp);
    for (int i = 0; i < nExp && i < nRx && i < 32; i++)
      checkEq(tag, rxBytes[i], expBytes[i]);
  endtask

  // R8: reset values at the ports
  task automatic testReset();
    doReset();
    checkEq("R8 byteReady", byteReady, 0);
    checkEq("R8 overrun", overrun, 0);
    checkEq("R8 byteOut", byteOut, 0);
  endtask

  // R1 R2 R3 R5: mixed zero runs after a long idle stretch
  task automatic testMixed();
    doReset();
    repeat (8 * T) @(negedge clk);  // idle timeouts must store nothing (R3)
    oneAfterZeros(0, 1);
    oneAfterZeros(1, 0);
    oneAfterZeros(0, 0);
    oneAfterZeros(2, 0);
    oneAfterZeros(1, 0);
    oneAfterZeros(0, 0);
    oneAfterZeros(3, 0);
    closeStream();
    checkEq("R5 first byte literal", rxBytes[0], 8'hB2);
    compareStream("R2 mixed zeros");
  endtask

  // R1 R5: runs of ones
  task automatic testOnes();
    doReset();
    oneAfterZeros(0, 1);
    for (int i = 0; i < 12; i++) oneAfterZeros(0, 0);
    closeStream();
    checkEq("R1 all ones byte", rxBytes[0], 8'hFF);
    compareStream("R1 ones stream");
  endtask

  // R3: a long gap gives exactly MZ zeros, then idle
  task automatic testLongGap();
    doReset();
    oneAfterZeros(0, 1);
    oneAfterZeros(6, 0);
    oneAfterZeros(0, 0);
    oneAfterZeros(0, 0);
    closeStream();
    checkEq("R3 idle after zero run", rxBytes[0], 8'h8E);
    compareStream("R3 long gap");
  endtask

  // R4: edges coinciding exactly with timer expiry
  task automatic testCollision();
    doReset();
    emitEdge(0);     modelPush(1);
    emitEdge(T);     modelPush(1);
    emitEdge(2 * T); modelPush(0); modelPush(1);
    for (int i = 0; i < 4; i++) begin emitEdge(T); modelPush(1); end
    repeat (20) @(negedge clk);
    checkEq("R4 collision byte count", nRx, 1);
    checkEq("R4 edge wins over timeout", rxBytes[0], 8'hDF);
    closeStream();
  endtask

  // R6 R7: host stalls, overrun, then acknowledge
  task automatic testOverrun();
    doReset();
    autoAck = 1'b0;
    emitEdge(0);
    for (int i = 0; i < 7; i++) emitEdge(T / 2);
    repeat (5 * T) @(negedge clk);
    checkEq("R6 ready held", byteReady, 1);
    checkEq("R6 byte held", byteOut, 8'hFF);
    checkEq("R7 no overrun yet", overrun, 0);
    emitEdge(T / 2);
    for (int i = 0; i < 4; i++) emitEdge(T / 2);
    repeat (10) @(negedge clk);
    checkEq("R7 overrun set", overrun, 1);
    checkEq("R7 newer byte shown", byteOut, 8'h1F);
    checkEq("R6 ready still high", byteReady, 1);
    manualAck = 1'b1;
    @(negedge clk);
    manualAck = 1'b0;
    checkEq("R6 ready drops after ack", byteReady, 0);
    repeat (5) @(negedge clk);
    checkEq("R7 overrun sticky", overrun, 1);
    checkEq("R6 stays low", byteReady, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    testReset();
    testMixed();
    testOnes();
    testLongGap();
    testCollision();
    testOverrun();
    finish();
  end
endmodule